// File: doc/BRIEF.md
# Hit count readout formatter

This block turns the per-channel hit counts of one front-end chip into the word stream that fills a hit-count readout buffer. A level-2 accept pulse makes it emit a fixed seven-word record. The first word is a header that packs a bunch number, the board slot address, the chip serial number and the chip type. Six count words follow. Each count word holds eight 4-bit nibbles, and each nibble carries one channel's on/off status and its hit count, which is clamped to 4. Together the six words cover 48 channels.

The bunch number comes from an internal 8-bit counter. The counter clears on the bunch-zero marker and steps once for each bunch clock enable. A programmable offset is added to it when the header is built. All inputs are sampled on the accept edge, so later changes to the counts or to the static fields do not alter a record that is already being emitted. Words come out one per clock with a valid strobe.

Top module: `hit_count_formatter`

## Requirements
- R1: A `l2_accept` high at a clock edge while the block is idle starts a record. `word_valid` is high for exactly the seven cycles after that edge, one word per cycle, with word index 0 (header) first and index 6 last. It then drops.
- R2: The header is laid out as follows. Bits 31..23 are `chip_type`. Bits 22..13 are `chip_serial`. Bits 12..8 are `slot_addr`. Bits 7..0 are the bunch number.
- R3: The bunch counter is 8 bits wide and wraps from 255 to 0. It clears to 0 on an edge where `bunch_zero` is high; this takes priority over `bunch_tick`. Otherwise it adds 1 on each edge where `bunch_tick` is high.
- R4: The header bunch field is `(counter + bunch_offset) mod 256`. The counter value used is the one held before the accept edge, so a tick on that same edge is not included.
- R5: Count word n (n = 1..6) carries channels 8(n-1) to 8(n-1)+7. Channel 8(n-1)+i sits in bits 4i+3..4i. For example, channel 0 is in word 1 bits 3..0 and channel 47 is in word 6 bits 31..28.
- R6: In each nibble, bit 3 is `chan_on` of that channel. Bits 2..0 are its 3-bit count from `hit_count[3c+2:3c]`, with values 5, 6 and 7 replaced by 4.
- R7: Counts, channel status, offset, slot, serial and type are captured on the accept edge. Changes to them during emission do not alter the record.
- R8: A `l2_accept` that arrives while a record is being emitted is ignored. It neither restarts nor lengthens the record.
- R9: While `word_valid` is low, `word_out` is zero.
- R10: After reset `word_valid` is low and the bunch counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bunch_zero | input | 1 | Bunch-zero marker, clears the bunch counter |
| bunch_tick | input | 1 | Bunch clock enable, advances the bunch counter |
| bunch_offset | input | 8 | Offset added to the bunch number in the header |
| slot_addr | input | 5 | Board geographic slot address |
| chip_serial | input | 10 | Chip serial number |
| chip_type | input | 9 | Chip type code |
| l2_accept | input | 1 | Level-2 accept, starts a record |
| hit_count | input | 144 | 48 channel counts, 3 bits each, channel c at bits 3c+2..3c |
| chan_on | input | 48 | Per-channel on/off status |
| word_out | output | 32 | Record word |
| word_valid | output | 1 | High while word_out carries a record word |

## Verification
Two events can fall on the same clock edge in this block. One is the bunch counter update, which may be a clear, a tick or both. The other is the header capture on an accept. The bench provokes both cases. In the first, it raises `bunch_zero` and `bunch_tick` together, lets a known number of ticks run, and then asserts `l2_accept` with the tick still high. The expected header therefore uses the pre-edge count, taken after a clear that won over the tick. In the second, it raises a second accept in the middle of a record and checks that the word sequence stays seven long and returns to idle.

// File: rtl/hit_count_formatter.sv
module hit_count_formatter #(
  parameter int NCH = 48,
  parameter int CW = 3,
  parameter int CMAX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bunch_zero,
  input  logic            bunch_tick,
  input  logic [7:0]      bunch_offset,
  input  logic [4:0]      slot_addr,
  input  logic [9:0]      chip_serial,
  input  logic [8:0]      chip_type,
  input  logic            l2_accept,
  input  logic [NCH*CW-1:0] hit_count,
  input  logic [NCH-1:0]  chan_on,
  output logic [31:0]     word_out,
  output logic            word_valid
);
  localparam int NWORD = NCH / 8;
  localparam int TOTAL = NWORD + 1;
  localparam int IW = $clog2(TOTAL);

  logic [7:0] bunch_q;
  logic [31:0] head_q;
  logic [NWORD-1:0][31:0] cw_d, cw_q;
  logic [IW-1:0] idx_q, cidx;
  logic busy_q;

  for (genvar g = 0; g < NCH; g++) begin : g_nib
    logic [CW-1:0] raw;
    assign raw = hit_count[CW*g +: CW];
    assign cw_d[g/8][4*(g%8) +: 4] = {chan_on[g], (raw > CW'(CMAX)) ? 3'(CMAX) : 3'(raw)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          bunch_q <= '0;
    else if (bunch_zero) bunch_q <= '0;
    else if (bunch_tick) bunch_q <= bunch_q + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      head_q <= '0;
      cw_q   <= '0;
    end else if (!busy_q) begin
      if (l2_accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        head_q <= {chip_type, chip_serial, slot_addr, bunch_q + bunch_offset};
        cw_q   <= cw_d;
      end
    end else if (idx_q == IW'(TOTAL - 1)) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cidx = idx_q - 1'b1;
  assign word_valid = busy_q;
  assign word_out = !busy_q ? '0 : (idx_q == '0) ? head_q : cw_q[cidx];
endmodule

module hit_count_formatter_chk #(
  parameter int TOTAL = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  slot_addr,
  input logic [9:0]  chip_serial,
  input logic [8:0]  chip_type,
  input logic [31:0] word_out,
  input logic        word_valid
);
  localparam int RW = $clog2(TOTAL + 1);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= word_valid ? run_q + 1'b1 : '0;
  end

  function automatic bit counts_ok(input logic [31:0] w);
    for (int i = 0; i < 8; i++) if (w[4*i +: 3] > 3'd4) return 1'b0;
    return 1'b1;
  endfunction

  a_r1_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> run_q < RW'(TOTAL));
  a_r1_run_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_valid) |-> run_q == RW'(TOTAL));
  a_r2_header_fields: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> word_out[31:8] == {$past(chip_type), $past(chip_serial), $past(slot_addr)});
  a_r6_count_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && run_q != '0) |-> counts_ok(word_out));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> word_out == '0);
endmodule

bind hit_count_formatter hit_count_formatter_chk #(.TOTAL(TOTAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .chip_serial(chip_serial),
  .chip_type(chip_type), .word_out(word_out), .word_valid(word_valid)
);

// File: tb/hit_count_formatter_test.sv
module hit_count_formatter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bunch_zero = 1'b0, bunch_tick = 1'b0, l2_accept = 1'b0;
  logic [7:0] bunch_offset = '0;
  logic [4:0] slot_addr = '0;
  logic [9:0] chip_serial = '0;
  logic [8:0] chip_type = '0;
  logic [2:0] hc [48];
  logic [47:0] chan_on = '0;
  logic [143:0] hit_count;
  logic [31:0] word_out;
  logic word_valid;

  int tests = 0, fails = 0;
  logic [31:0] expw [7];

  always #4 clk = ~clk;

  for (genvar g = 0; g < 48; g++) begin : g_pack
    assign hit_count[3*g +: 3] = hc[g];
  end

  hit_count_formatter uut (
    .clk(clk), .rst_n(rst_n), .bunch_zero(bunch_zero), .bunch_tick(bunch_tick),
    .bunch_offset(bunch_offset), .slot_addr(slot_addr), .chip_serial(chip_serial),
    .chip_type(chip_type), .l2_accept(l2_accept), .hit_count(hit_count),
    .chan_on(chan_on), .word_out(word_out), .word_valid(word_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_expected(input logic [7:0] bunch);
    expw[0] = {chip_type, chip_serial, slot_addr, bunch};
    for (int k = 1; k < 7; k++) begin
      for (int i = 0; i < 8; i++) begin
        int ch = 8*(k-1) + i;
        logic [2:0] c = (hc[ch] > 3'd4) ? 3'd4 : hc[ch];
        expw[k][4*i +: 4] = {chan_on[ch], c};
      end
    end
  endtask

  task automatic run_event(input logic [7:0] bunch, input bit mutate, input bit reaccept, input string tag);
    build_expected(bunch + bunch_offset);
    l2_accept = 1'b1;
    @(negedge clk);
    l2_accept = 1'b0;
    for (int i = 0; i < 7; i++) begin
      chk(word_valid === 1'b1, {tag, " R1 valid"}, 32'(word_valid), 32'd1);
      chk(word_out === expw[i], $sformatf("%s R2/R5 word%0d", tag, i), word_out, expw[i]);
      if (mutate && i == 2) begin
        for (int c = 0; c < 48; c++) hc[c] = ~hc[c];
        chan_on = ~chan_on;
        slot_addr = ~slot_addr;
        bunch_offset = bunch_offset + 8'd9;
      end
      if (reaccept && i == 3) l2_accept = 1'b1;
      @(negedge clk);
      l2_accept = 1'b0;
    end
    chk(word_valid === 1'b0, {tag, " R1/R8 end"}, 32'(word_valid), 32'd0);
    chk(word_out === 32'd0, {tag, " R9 idle"}, word_out, 32'd0);
    @(negedge clk);
    chk(word_valid === 1'b0, {tag, " R8 stays idle"}, 32'(word_valid), 32'd0);
  endtask

  task automatic zero_counter();
    bunch_zero = 1'b1;
    @(negedge clk);
    bunch_zero = 1'b0;
  endtask

  task automatic t_reset();
    chk(word_valid === 1'b0, "R10 reset valid", 32'(word_valid), 32'd0);
    chk(word_out === 32'd0, "R9 reset word", word_out, 32'd0);
    bunch_offset = 8'd0;
    run_event(8'd0, 0, 0, "R10 counter");
  endtask

  task automatic t_basic();
    for (int c = 0; c < 48; c++) hc[c] = 3'(c % 5);
    chan_on = 48'hA5A5_0F0F_F00F;
    slot_addr = 5'h13; chip_serial = 10'h2B7; chip_type = 9'h1C5;
    bunch_offset = 8'd0;
    zero_counter();
    run_event(8'd0, 0, 0, "R5 basic");
  endtask

  task automatic t_clamp();
    for (int c = 0; c < 48; c++) hc[c] = 3'(3 + (c % 5));
    chan_on = '1;
    run_event(8'd0, 0, 0, "R6 clamp");
    chan_on = '0;
    run_event(8'd0, 0, 0, "R6 off");
  endtask

  task automatic t_bunch();
    bunch_offset = 8'd250;
    zero_counter();
    bunch_tick = 1'b1;
    repeat (300) @(negedge clk);
    bunch_tick = 1'b0;
    run_event(8'd44, 0, 0, "R3/R4 wrap");
  endtask

  task automatic t_collision();
    bunch_offset = 8'd17;
    bunch_zero = 1'b1; bunch_tick = 1'b1;
    @(negedge clk);
    bunch_zero = 1'b0;
    repeat (5) @(negedge clk);
    run_event(8'd5, 0, 0, "R3/R4 same edge");
    bunch_tick = 1'b0;
  endtask

  task automatic t_capture();
    bunch_offset = 8'd3;
    zero_counter();
    for (int c = 0; c < 48; c++) hc[c] = 3'(c % 8);
    chan_on = 48'h0123_4567_89AB;
    run_event(8'd0, 1, 0, "R7 capture");
  endtask

  task automatic t_ignore();
    bunch_offset = 8'd0;
    run_event(8'd0, 0, 1, "R8 re-accept");
  endtask

  initial begin
    for (int c = 0; c < 48; c++) hc[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clamp();
    t_bunch();
    t_collision();
    t_capture();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule